// File: doc/BRIEF.md
# Two-Level Page Walker with Large-Page Support

The walker turns a virtual address that missed in a translation cache into a physical address. It runs the 32-bit two-level scheme. A directory base register picks one 4 KiB directory of 1024 four-byte entries. Each directory entry either names a 4 KiB table of 1024 four-byte entries, whose entries name 4 KiB pages, or, when large pages are switched on, maps one 4 MiB page directly. A wide-address switch lets a large-page entry supply four extra frame bits, so the page can sit anywhere in a 36-bit physical space.

A miss arrives on a valid/ready request port. The walker takes a new request only when it is idle. It then issues one or two 32-bit reads on a memory port. That port has a valid/ready request channel and a response strobe with no back-pressure. It returns the physical address, a large-page flag for filling the cache, or a fault, on a valid/ready result port. Back-pressure rules: a memory request keeps its address and stays valid until the memory accepts it. A result stays valid and unchanged until the consumer accepts it. While a walk or an unaccepted result is pending, the request port shows not-ready. The directory base and both enables are sampled when the request is taken, and later changes do not affect that walk.

Top module: `pg_walker`

## Requirements
- R1: After reset, and whenever neither a walk nor a pending result exists, req_ready is 1, and res_valid and mem_req_valid are 0. A request is taken on req_valid && req_ready, and req_ready stays 0 from then until the result is accepted.
- R2: The first read of a walk goes to address {dir_base[31:12], va[31:22], 2'b00}.
- R3: If the directory entry has bit 0 = 1 and bit 7 = 1, and large pages were enabled at acceptance, the walk makes exactly one read. It then returns res_large = 1, res_fault = 0 and res_pa[31:0] = {entry[31:22], va[21:0]}.
- R4: For such a large page, res_pa[35:32] is entry[16:13] when the wide-address enable was set at acceptance, and 0 otherwise. Every 4 KiB result has res_pa[35:32] = 0.
- R5: With large pages disabled at acceptance, directory entry bit 7 is ignored, and a present entry always leads to a second read.
- R6: The second read goes to {entry[31:12], va[21:12], 2'b00}. If that table entry has bit 0 = 1, the result is res_pa = {4'h0, pte[31:12], va[11:0]}, res_large = 0, res_fault = 0.
- R7: If bit 0 of any entry read is 0, the walk ends at once with res_fault = 1, res_pa = 0 and res_large = 0, and makes no further read.
- R8: mem_req_valid and mem_req_addr hold until mem_req_ready. A response strobe counts only while a read is outstanding, and strobes at any other time have no effect.
- R9: While res_valid is 1 and res_ready is 0, the result outputs hold. One cycle after acceptance, res_valid is 0 and req_ready is 1.
- R10: Changing either enable during a walk leaves that walk's result as fixed by the values sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker can take a request |
| req_va | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Directory base register (bits 31:12 used) |
| big_pg_en | input | 1 | Large-page enable |
| wide_pa_en | input | 1 | 36-bit large-page frame enable |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_pa | output | 36 | Physical address (0 on fault) |
| res_large | output | 1 | Result maps a 4 MiB page |
| res_fault | output | 1 | Walk hit a non-present entry |

## Verification
Two events can coincide. The directory response that decides between stopping and descending can arrive in the same cycle that software flips the large-page or wide-address enable. The bench provokes this by flipping both enables on exactly the cycle each response strobe is driven. It judges the result against the values sampled when the request was taken. Separately, stray response strobes are driven while the walker is idle, and the bench requires that no result or read appears. It then requires that the next walk translates correctly.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_RD_TBL,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pw_ctx.sv
module pw_ctx #(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [HI_W-1:0]   base_i,
  input  logic              lp_i,
  input  logic              ext_i,
  output logic [ADDR_W-1:0] va_q,
  output logic [HI_W-1:0]   base_q,
  output logic              lp_q,
  output logic              ext_q
);
  // Snapshot of everything a walk depends on, taken with the request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      lp_q   <= 1'b0;
      ext_q  <= 1'b0;
    end else if (take) begin
      va_q   <= va_i;
      base_q <= base_i;
      lp_q   <= lp_i;
      ext_q  <= ext_i;
    end
  end
endmodule

// File: rtl/pw_addr.sv
module pw_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int PG_W   = 12
) (
  input  logic                    use_tbl,
  input  logic [ADDR_W-PG_W-1:0]  base_hi,
  input  logic [ADDR_W-PG_W-1:0]  va_hi,
  input  logic [ADDR_W-PG_W-1:0]  pde_hi,
  output logic [ADDR_W-1:0]       addr
);
  localparam int ENT_B = PG_W - IDX_W;
  localparam int HI_W  = ADDR_W - PG_W;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;

  // Directory index is the top slice of the VA, table index the next one.
  assign dir_addr = {base_hi, va_hi[HI_W-1 -: IDX_W], {ENT_B{1'b0}}};
  assign tbl_addr = {pde_hi, va_hi[IDX_W-1:0], {ENT_B{1'b0}}};
  assign addr     = use_tbl ? tbl_addr : dir_addr;
endmodule

// File: rtl/pw_dec.sv
module pw_dec #(
  parameter int ADDR_W  = 32,
  parameter int PA_W    = 36,
  parameter int IDX_W   = 10,
  parameter int PG_W    = 12,
  parameter int EXT_LSB = 13,
  parameter int PS_BIT  = 7,
  parameter int P_BIT   = 0
) (
  input  logic [ADDR_W-1:0]       ent,
  input  logic [PG_W+IDX_W-1:0]   va_lo,
  input  logic                    lp,
  input  logic                    ext,
  input  logic                    is_tbl,
  output logic                    present,
  output logic                    is_large,
  output logic [PA_W-1:0]         pa
);
  localparam int LG_OFF = PG_W + IDX_W;
  localparam int EXT_W  = PA_W - ADDR_W;

  logic [PA_W-1:0] pa_big;
  logic [PA_W-1:0] pa_small;

  assign present  = ent[P_BIT];
  // Size bit only matters for a directory entry when large pages are on.
  assign is_large = !is_tbl && lp && ent[PS_BIT];

  generate
    if (EXT_W > 0) begin : g_ext
      logic [EXT_W-1:0] hi_bits;
      assign hi_bits  = ext ? ent[EXT_LSB +: EXT_W] : '0;
      assign pa_big   = {hi_bits, ent[ADDR_W-1:LG_OFF], va_lo};
      assign pa_small = {{EXT_W{1'b0}}, ent[ADDR_W-1:PG_W], va_lo[PG_W-1:0]};
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ext;
      assign pa_big     = {ent[ADDR_W-1:LG_OFF], va_lo};
      assign pa_small   = {ent[ADDR_W-1:PG_W], va_lo[PG_W-1:0]};
    end
  endgenerate

  assign pa = is_large ? pa_big : pa_small;

  logic unused_ent;
  assign unused_ent = ^ent;
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  input  logic     res_ready,
  input  logic     present,
  input  logic     is_large,
  output walk_st_e state,
  output logic     req_ready,
  output logic     mem_req_valid,
  output logic     dir_load,
  output logic     finish
);
  logic     issued;
  logic     rsp_take;
  walk_st_e nxt;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = ((state == ST_RD_DIR) || (state == ST_RD_TBL)) && !issued;
  assign rsp_take      = issued && mem_rsp_valid;
  assign dir_load      = rsp_take && (state == ST_RD_DIR);
  assign finish        = rsp_take && ((state == ST_RD_TBL) || !present || is_large);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (req_valid) nxt = ST_RD_DIR;
      ST_RD_DIR: if (rsp_take) nxt = (!present || is_large) ? ST_DONE : ST_RD_TBL;
      ST_RD_TBL: if (rsp_take) nxt = ST_DONE;
      ST_DONE:   if (res_ready) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      state <= nxt;
      if (mem_req_valid && mem_req_ready) issued <= 1'b1;
      else if (rsp_take)                  issued <= 1'b0;
    end
  end

  // R8: an unaccepted read stays offered in the same phase
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(state)));

  // R8: a strobe with no read outstanding leaves the walk phase alone
  assert_stray_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !issued && (state != ST_IDLE) && (state != ST_DONE)) |=>
      ((state == ST_RD_DIR) || (state == ST_RD_TBL)));
endmodule

// File: rtl/pg_walker.sv
module pg_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PA_W    = 36,
  parameter int IDX_W   = 10,
  parameter int PG_W    = 12,
  parameter int EXT_LSB = 13,
  parameter int PS_BIT  = 7,
  parameter int P_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              big_pg_en,
  input  logic              wide_pa_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PA_W-1:0]   res_pa,
  output logic              res_large,
  output logic              res_fault
);
  localparam int HI_W   = ADDR_W - PG_W;
  localparam int LG_OFF = PG_W + IDX_W;
  localparam int EXT_W  = PA_W - ADDR_W;

  walk_st_e          state;
  logic              take;
  logic [ADDR_W-1:0] va_q;
  logic [HI_W-1:0]   base_q;
  logic              lp_q;
  logic              ext_q;
  logic [HI_W-1:0]   pde_hi_q;
  logic              dir_load;
  logic              finish;
  logic              present;
  logic              is_large;
  logic [PA_W-1:0]   pa;

  assign take = req_valid && req_ready;

  pw_ctx #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .va_i   (req_va),
    .base_i (dir_base[ADDR_W-1:PG_W]),
    .lp_i   (big_pg_en),
    .ext_i  (wide_pa_en),
    .va_q   (va_q),
    .base_q (base_q),
    .lp_q   (lp_q),
    .ext_q  (ext_q)
  );

  pw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .res_ready     (res_ready),
    .present       (present),
    .is_large      (is_large),
    .state         (state),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .dir_load      (dir_load),
    .finish        (finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pde_hi_q <= '0;
    else if (dir_load) pde_hi_q <= mem_rsp_data[ADDR_W-1:PG_W];
  end

  pw_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PG_W(PG_W)) u_addr (
    .use_tbl (state == ST_RD_TBL),
    .base_hi (base_q),
    .va_hi   (va_q[ADDR_W-1:PG_W]),
    .pde_hi  (pde_hi_q),
    .addr    (mem_req_addr)
  );

  pw_dec #(
    .ADDR_W(ADDR_W), .PA_W(PA_W), .IDX_W(IDX_W), .PG_W(PG_W),
    .EXT_LSB(EXT_LSB), .PS_BIT(PS_BIT), .P_BIT(P_BIT)
  ) u_dec (
    .ent      (mem_rsp_data),
    .va_lo    (va_q[LG_OFF-1:0]),
    .lp       (lp_q),
    .ext      (ext_q),
    .is_tbl   (state == ST_RD_TBL),
    .present  (present),
    .is_large (is_large),
    .pa       (pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_pa    <= '0;
      res_large <= 1'b0;
      res_fault <= 1'b0;
    end else if (finish) begin
      res_pa    <= present ? pa : '0;
      res_large <= present && is_large;
      res_fault <= !present;
    end
  end

  assign res_valid = (state == ST_DONE);

  logic unused_base_lo;
  assign unused_base_lo = ^dir_base[PG_W-1:0];

  // R1: one walk at a time
  assert_single_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  assert_no_read_with_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!mem_req_valid && !req_ready));

  // R3: a large page keeps the low 22 VA bits
  assert_large_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_large) |-> (!res_fault && (res_pa[LG_OFF-1:0] == va_q[LG_OFF-1:0])));

  // R5: a large result only when the feature was on at acceptance
  assert_large_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_large) |-> lp_q);

  // R7: a fault carries no translation
  assert_fault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> ((res_pa == '0) && !res_large));

  // R8: offered address holds until taken
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R9: result holds under back-pressure
  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_pa) && $stable(res_large) && $stable(res_fault)));

  generate
    if (EXT_W > 0) begin : g_chk_ext
      // R4: upper frame bits stay zero unless widened large page
      assert_narrow_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (!ext_q || !res_large)) |-> (res_pa[PA_W-1:ADDR_W] == '0));
    end
  endgenerate
endmodule

// File: tb/pg_walker_tb_top.sv
`timescale 1ns/1ps
module pg_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] dir_base = 32'h0040_0000;
  logic        big_pg_en = 1'b0;
  logic        wide_pa_en = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [35:0] res_pa;
  logic        res_large;
  logic        res_fault;

  always #2.5 clk = ~clk;

  pg_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .dir_base(dir_base), .big_pg_en(big_pg_en), .wide_pa_en(wide_pa_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_pa(res_pa), .res_large(res_large), .res_fault(res_fault)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int          cnt = 0;
  int          reads = 0;
  int          cyc = 0;
  logic [31:0] addr_l = '0;
  logic [31:0] adr0 = '0;
  logic [31:0] adr1 = '0;
  bit          flip = 0;
  bit          stray = 0;
  logic [7:0]  bp_pat = 8'hFF;

  // Memory contents computed from the address: table region when a[21:17]=11110
  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [9:0] k;
    k = a[11:2];
    if (a[21:17] == 5'b11110)
      return {a[31:12] ^ {k, 10'h155}, 11'h0, (k % 6 != 4)};
    else
      return {k ^ 10'h2A5, 5'b11110, k[3:0] ^ 4'h9, 1'b1, 4'h0, k[1] ^ k[4], 6'h0, (k % 5 != 2)};
  endfunction

  // Memory model: ready pattern, latency 1..3 cycles, optional enable flip
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_val(addr_l);
          if (flip) begin
            big_pg_en  = ~big_pg_en;
            wide_pa_en = ~wide_pa_en;
          end
        end
      end else if (stray) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFF_FFFF;
      end
      mem_req_ready = bp_pat[cyc % 8];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        addr_l = mem_req_addr;
        if (reads == 0) adr0 = mem_req_addr;
        if (reads == 1) adr1 = mem_req_addr;
        reads++;
        cnt = 1 + (cyc % 3);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input int hold, input bit use_flip);
    logic [31:0] pde, pte, da, ta;
    logic [35:0] epa, pa_seen;
    bit el, ef, lp_s, ex_s;
    int er;
    string tg;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    while (!req_ready) @(negedge clk);
    lp_s  = big_pg_en;
    ex_s  = wide_pa_en;
    reads = 0;
    flip  = use_flip;
    da  = {dir_base[31:12], va[31:22], 2'b00};
    pde = mem_val(da);
    ta  = {pde[31:12], va[21:12], 2'b00};
    pte = mem_val(ta);
    if (!pde[0]) begin
      er = 1; ef = 1; el = 0; epa = '0; tg = "R7";
    end else if (lp_s && pde[7]) begin
      er = 1; ef = 0; el = 1;
      epa = {ex_s ? pde[16:13] : 4'h0, pde[31:22], va[21:0]};
      tg = ex_s ? "R4" : "R3";
    end else begin
      er = 2;
      if (!pte[0]) begin ef = 1; el = 0; epa = '0; tg = "R7"; end
      else begin ef = 0; el = 0; epa = {4'h0, pte[31:12], va[11:0]}; tg = (pde[7] ? "R5" : "R6"); end
    end
    if (use_flip) tg = "R10";
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(res_pa == epa, {tg, " pa"}, 64'(res_pa), 64'(epa));
    chk(res_large == el, {tg, " large"}, 64'(res_large), 64'(el));
    chk(res_fault == ef, {tg, " fault"}, 64'(res_fault), 64'(ef));
    chk(reads == er, {tg, " read count"}, 64'(reads), 64'(er));
    chk(adr0 == da, "R2 dir addr", 64'(adr0), 64'(da));
    if (er == 2) chk(adr1 == ta, "R6 tbl addr", 64'(adr1), 64'(ta));
    pa_seen = res_pa;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(res_valid && (res_pa == pa_seen) && !req_ready, "R9 hold", 64'(res_pa), 64'(pa_seen));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R9 release", {62'h0, res_valid, req_ready}, 64'h1);
    if (use_flip) begin
      big_pg_en  = lp_s;
      wide_pa_en = ex_s;
      flip = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'b1011_0110; pats[2] = 8'h55; pats[3] = 8'b1110_1011;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'h1);
    chk(res_valid == 1'b0, "R1 reset result", 64'(res_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R1 reset read", 64'(mem_req_valid), 64'h0);

    // Sweep every directory index under all four enable combinations
    for (int m = 0; m < 4; m++) begin
      big_pg_en  = m[0];
      wide_pa_en = m[1];
      bp_pat     = pats[m];
      for (int i = 0; i < 1024; i++) begin
        logic [9:0] ix, tx;
        logic [11:0] ox;
        ix = i[9:0];
        tx = 10'((i * 37) % 1024);
        ox = 12'((i * 13) ^ 'hABC);
        walk({ix, tx, ox}, i % 3, 1'b0);
      end
    end

    // Enables flip on the same cycle as each response strobe (R10)
    bp_pat = 8'b1101_1011;
    for (int i = 0; i < 64; i++) begin
      big_pg_en  = i[0];
      wide_pa_en = i[1];
      walk({10'(i * 17), 10'(i * 5), 12'(i * 99)}, 1, 1'b1);
    end

    // Stray strobes while idle have no effect (R8)
    stray = 1;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      chk(!res_valid && !mem_req_valid && req_ready, "R8 stray idle",
          {61'h0, res_valid, mem_req_valid, req_ready}, 64'h1);
    end
    stray = 0;
    big_pg_en = 1'b1; wide_pa_en = 1'b1;
    walk(32'h8123_4567, 0, 1'b0);

    // Different directory base
    dir_base = 32'h1234_5000;
    bp_pat   = 8'b0111_0111;
    for (int i = 0; i < 64; i++) begin
      big_pg_en  = i[2];
      wide_pa_en = i[3];
      walk({10'(i * 29 + 3), 10'(i * 11), 12'(i * 7)}, i % 2, 1'b0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule